// File: doc/BRIEF.md
# Asynchronous Byte-Lane Static RAM Controller

This block connects a synchronous request port, with valid/ready handshaking, to an asynchronous 16-bit static RAM that has 21 address bits. Each request carries a read/write flag, a word address, write data and a two-bit lane mask. Mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8. The controller drives the memory's select, strobe and byte-enable pins from registers. It controls the shared data bus through a separate output enable, and it returns read data together with a one-clock valid pulse.

The access time is met by counting clock cycles. The strobe length is HOLD = ceil(ACCESS_PS / CLK_PS) clocks, which is 4 at the default 20 ns clock and 70 ns access. Each access is followed by one idle clock. In that clock the memory is deselected and the bus is released, so a read that follows a write never meets a driven bus. Only one access can be in flight at a time.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and directly after it is released, the pins are inactive: mem_cs_n=1, mem_cs=0, mem_we_n=1, mem_oe_n=1, mem_be_n=2'b11 and mem_dq_oe=0. req_ready is 1 once reset is released.
- R2: mem_cs_n is 0 and mem_cs is 1 during the HOLD access clocks of a request, and only then. A request is accepted at the edge where req_valid and req_ready are both 1. Its access clocks are the HOLD clocks after that edge.
- R3: During a write access, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1, and mem_dq_out equals the accepted write data.
- R4: During a read access, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0. mem_we_n and mem_oe_n are never low together.
- R5: Every access lasts exactly HOLD clocks. mem_addr, mem_be_n and mem_dq_out stay constant for the whole access. mem_be_n[i] is the inverse of accepted mask bit i.
- R6: The clock after every access is idle. In it the memory is deselected, all strobes and byte enables are high, and mem_dq_oe is 0.
- R7: req_ready is 0 from the acceptance edge until the idle clock ends. It then returns to 1.
- R8: For a read, the data on mem_dq_in is captured in the last access clock. rsp_valid is high for exactly one clock, the idle clock. In rsp_rdata, the lanes whose mask bit is 0 read as zero.
- R9: A request with mask 2'b00 keeps mem_be_n at 2'b11 for its whole access and still completes with normal timing. A read with this mask returns rsp_rdata=0.
- R10: mem_dq_oe is never 1 while mem_oe_n is 0.
- R11: Request fields that are presented while req_ready is 0 do not affect the pins and are not executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit i selects data bits 8i+7:8i |
| rsp_valid | output | 1 | One-clock read-data valid pulse |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | 21 | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable of the memory |
| mem_be_n | output | 2 | Active-low byte enables, bit 0 = low lane |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Bus driver enable of the controller |
| mem_dq_in | input | 16 | Data read from the memory bus |

## Verification
The assertions rely on the requester following valid/ready. A request is taken only in a clock where req_ready is high, and the timing checks assume that the handshake is sampled on rising edges only. The bench changes the request inputs only on falling edges. While req_ready is low, it deliberately presents scrambled fields with req_valid held high, so that R11 is exercised inside the handshake rules. The memory model in the bench answers only when the pins form a legal read. It returns a fixed filler pattern on lanes that are not enabled, so a failure to zero a masked lane shows up as a data mismatch.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_GAP    = 2'd2
   } ctl_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/sram_hold_timer.sv
module sram_hold_timer #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic last
);

   if (HOLD < 1) begin : g_bad_hold
      $error("sram_hold_timer: HOLD must be at least 1");
   end

   if (HOLD == 1) begin : g_single
      // Every access clock is also the last one.
      assign last = 1'b1;
      logic unused_in;
      assign unused_in = ^{clk, rst_n, start, run};
   end else begin : g_count
      localparam int CW = $clog2(HOLD);
      localparam logic [CW-1:0] LAST_VAL = CW'(HOLD - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (start) begin
            cnt <= '0;
         end else if (run && !last) begin
            cnt <= cnt + 1'b1;
         end
      end

      assign last = (cnt == LAST_VAL);

      assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LAST_VAL);
   end

endmodule

// File: rtl/sram_byte_lanes.sv
module sram_byte_lanes #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W/8-1:0] req_mask,
   input  logic [DATA_W/8-1:0] held_mask,
   input  logic [DATA_W-1:0]   rd_in,
   output logic [DATA_W/8-1:0] be_n,
   output logic [DATA_W-1:0]   rd_masked
);

   localparam int LANES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("sram_byte_lanes: DATA_W must be a multiple of 8");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be_n[g]            = ~req_mask[g];
      assign rd_masked[g*8 +: 8] = held_mask[g] ? rd_in[g*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W    = 21,
   parameter int DATA_W    = 16,
   parameter int CLK_PS    = 20000,
   parameter int ACCESS_PS = 70000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_mask,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_cs_n,
   output logic                mem_cs,
   output logic                mem_we_n,
   output logic                mem_oe_n,
   output logic [DATA_W/8-1:0] mem_be_n,
   output logic [DATA_W-1:0]   mem_dq_out,
   output logic                mem_dq_oe,
   input  logic [DATA_W-1:0]   mem_dq_in
);

   localparam int LANES = DATA_W / 8;
   localparam int HOLD  = ceil_div(ACCESS_PS, CLK_PS);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_lane_ctrl: ADDR_W must be positive");
   end
   if (CLK_PS < 1 || ACCESS_PS < 1) begin : g_bad_time
      $error("sram_lane_ctrl: timing parameters must be positive");
   end

   ctl_state_t         state;
   logic               wr_q;
   logic [LANES-1:0]   mask_q;
   logic               accept;
   logic               last;
   logic [LANES-1:0]   be_n_req;
   logic [DATA_W-1:0]  rd_masked;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;

   sram_hold_timer #(.HOLD(HOLD)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .run   (state == ST_ACCESS),
      .last  (last)
   );

   sram_byte_lanes #(.DATA_W(DATA_W)) u_lanes (
      .req_mask  (req_mask),
      .held_mask (mask_q),
      .rd_in     (mem_dq_in),
      .be_n      (be_n_req),
      .rd_masked (rd_masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         wr_q       <= 1'b0;
         mask_q     <= '0;
         mem_addr   <= '0;
         mem_cs_n   <= 1'b1;
         mem_cs     <= 1'b0;
         mem_we_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_be_n   <= '1;
         mem_dq_out <= '0;
         mem_dq_oe  <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state      <= ST_ACCESS;
                  wr_q       <= req_write;
                  mask_q     <= req_mask;
                  mem_addr   <= req_addr;
                  mem_cs_n   <= 1'b0;
                  mem_cs     <= 1'b1;
                  mem_we_n   <= ~req_write;
                  mem_oe_n   <= req_write;
                  mem_be_n   <= be_n_req;
                  mem_dq_out <= req_write ? req_wdata : '0;
                  mem_dq_oe  <= req_write;
               end
            end
            ST_ACCESS: begin
               if (last) begin
                  state     <= ST_GAP;
                  mem_cs_n  <= 1'b1;
                  mem_cs    <= 1'b0;
                  mem_we_n  <= 1'b1;
                  mem_oe_n  <= 1'b1;
                  mem_be_n  <= '1;
                  mem_dq_oe <= 1'b0;
                  if (!wr_q) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= rd_masked;
                  end
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   // R10: the controller never fights the memory's output drivers
   assert_bus_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n));

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   assert_strobe_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || !mem_oe_n) |-> (!mem_cs_n && mem_cs));

   assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACCESS && $past(state == ST_ACCESS))
         |-> ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_dq_out)));

   assert_gap_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP) |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n
                             && (mem_be_n == '1) && !mem_dq_oe));

   assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_mask == '0) |=> (mem_be_n == '1));

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;

   localparam int AW   = 21;
   localparam int DW   = 16;
   localparam int TCLK = 20000;
   localparam int TACC = 70000;
   localparam int H    = (TACC + TCLK - 1) / TCLK;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_mask = 2'b00;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]    mem_be_n;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #10ns clk = ~clk;

   sram_lane_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(TCLK), .ACCESS_PS(TACC)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // Memory model: 64 words, indexed by the low address bits
   logic [DW-1:0] mem [64];
   initial for (int i = 0; i < 64; i++) mem[i] = 16'hC000 + 16'(i * 3);

   always_comb begin
      for (int l = 0; l < 2; l++) begin
         if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n && !mem_be_n[l])
            mem_dq_in[l*8 +: 8] = mem[mem_addr[5:0]][l*8 +: 8];
         else
            mem_dq_in[l*8 +: 8] = 8'h5A;
      end
   end

   always @(posedge clk) begin
      if (!mem_cs_n && mem_cs && !mem_we_n && mem_dq_oe) begin
         for (int l = 0; l < 2; l++)
            if (!mem_be_n[l]) mem[mem_addr[5:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
      end
   end

   // Reference model, advanced on every rising edge
   int            m_state = 0;
   int            m_cnt = 0;
   logic          m_wr = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_wdata = '0;
   logic [1:0]    m_mask = 2'b00;
   logic          m_rv = 1'b0;
   logic [DW-1:0] m_rdata = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_rv = 1'b0; m_rdata = '0;
      end else begin
         m_rv = 1'b0;
         case (m_state)
            0: if (req_valid) begin
                  m_state = 1; m_cnt = 0; m_wr = req_write; m_addr = req_addr;
                  m_wdata = req_wdata; m_mask = req_mask;
               end
            1: if (m_cnt == H - 1) begin
                  if (!m_wr) begin
                     m_rv = 1'b1;
                     m_rdata = mem[m_addr[5:0]]
                               & {{8{m_mask[1]}}, {8{m_mask[0]}}};
                  end
                  m_state = 2;
               end else m_cnt++;
            default: m_state = 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // Compare on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit sel = (m_state == 1);
         chk(req_ready == (m_state == 0), "R7 req_ready", 32'(req_ready), 32'(m_state == 0));
         chk(mem_cs_n == !sel && mem_cs == sel, "R2 select pair",
             {mem_cs_n, mem_cs}, {!sel, sel});
         chk(mem_we_n == !(sel && m_wr), "R3 we_n", 32'(mem_we_n), 32'(!(sel && m_wr)));
         chk(mem_oe_n == !(sel && !m_wr), "R4 oe_n", 32'(mem_oe_n), 32'(!(sel && !m_wr)));
         chk(mem_dq_oe == (sel && m_wr), "R6 dq_oe", 32'(mem_dq_oe), 32'(sel && m_wr));
         chk(mem_be_n == (sel ? ~m_mask : 2'b11), "R5 R9 be_n",
             32'(mem_be_n), 32'(sel ? ~m_mask : 2'b11));
         chk(!(mem_dq_oe && !mem_oe_n), "R10 bus contention",
             {mem_dq_oe, mem_oe_n}, 32'b01);
         if (sel) chk(mem_addr == m_addr, "R5 R11 addr", 32'(mem_addr), 32'(m_addr));
         if (sel && m_wr) chk(mem_dq_out == m_wdata, "R3 R11 wdata",
                              32'(mem_dq_out), 32'(m_wdata));
         chk(rsp_valid == m_rv, "R8 rsp_valid", 32'(rsp_valid), 32'(m_rv));
         if (m_rv) chk(rsp_rdata == m_rdata, "R8 R9 rsp_rdata",
                       32'(rsp_rdata), 32'(m_rdata));
      end
   end

   task automatic send(input logic wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [1:0] m);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      // R11: scrambled fields with valid high while busy
      req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1 pins in reset", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
          7'b1011110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_cs_n && !mem_dq_oe, "R1 after reset",
          {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);
      send(1'b1, 21'h000005, 16'h1234, 2'b11);
      send(1'b0, 21'h000005, 16'h0000, 2'b11);
      send(1'b1, 21'h1FFFC9, 16'hAB77, 2'b01);
      send(1'b0, 21'h1FFFC9, 16'h0000, 2'b11);
      send(1'b1, 21'h0A0012, 16'h99EE, 2'b10);
      send(1'b0, 21'h0A0012, 16'h0000, 2'b01);
      send(1'b0, 21'h0A0012, 16'h0000, 2'b10);
      send(1'b1, 21'h000021, 16'hFFFF, 2'b00);
      send(1'b0, 21'h000021, 16'h0000, 2'b11);
      send(1'b0, 21'h000021, 16'h0000, 2'b00);
      send(1'b1, 21'h15553F, 16'h5AA5, 2'b11);
      send(1'b0, 21'h15553F, 16'h0000, 2'b11);
      repeat (H + 4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<=5000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule